// File: doc/BRIEF.md
# PCI Type-0 Configuration Register Space

This block holds the configuration space of a single-function PCI target. It decodes type-0 configuration reads and writes that arrive with IDSEL asserted. The 256-byte space is sparse: flops exist only for the fields that software must be able to change. Every other location is hard-wired or reads as zero, which keeps the read multiplexer and the write decode narrow. The vendor and device identifiers come from input ports, so one netlist can be given different identities.

Each cycle that presents a configuration command is one access. A claimed read returns its dword on `rdata_o` one clock later, with `rvalid_o` high for that one cycle. A claimed write takes effect at the clock edge that samples it.

The block also exports the command enables and the 1 MB memory window. The target logic uses the window to decode memory cycles. The same logic reports parity and system errors into the status bits.

Top module: `pci_cfg_space`

## Requirements
- R1: `cfg_hit_o` is high, combinationally, exactly when `idsel_i`=1, `cmd_i` is 4'b1010 (read) or 4'b1011 (write), and `ad_i[1:0]`=2'b00. Only such cycles read or write the space.
- R2: A claimed read raises `rvalid_o` for one cycle on the following clock. That cycle carries the addressed dword on `rdata_o`. `rvalid_o` is 0 in every other cycle.
- R3: Offset 0x00 reads {`device_id_i`, `vendor_id_i`}. Offset 0x08 reads {CLASS_CODE, 8'h00}. Offsets 0x40–0xFF, and every header dword other than 0x00, 0x04, 0x08, 0x10 and 0x3C, read as zero.
- R4: Offset 0x10 is the memory window base. Bits [19:0] read 0, so the window is 1 MB, 32-bit and non-prefetchable. Bits [31:20] are writable.
- R5: Offset 0x04 bits [15:0] form the command word. Only bit 1 (memory enable), bit 6 (parity response) and bit 8 (system-error enable) are writable. They drive `mem_en_o`, `perr_resp_o` and `serr_en_o`.
- R6: Offset 0x3C reads {16'h0, 8'h01, line}. The 8'h01 reports interrupt pin A. The line field is writable.
- R7: `mem_hit_o` is high exactly when `mem_en_o`=1 and `mem_addr_i[31:20]` equals the base stored in R4.
- R8: Offset 0x04 bit 31 (detected parity error) is set by `perr_event_i`. Bit 30 (signalled system error) is set by `serr_event_i`. Writing 1 to a bit clears it. When a set event and a clearing write fall in the same cycle, the set wins.
- R9: Byte enable `be_i[n]` (active high) gates write byte lane n. Writes to disabled lanes, read-only bits and unimplemented offsets leave all readable state unchanged.
- R10: While `rst_ni` is low, the command bits, status bits, window base and interrupt line are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idsel_i | input | 1 | Configuration select for this function |
| cmd_i | input | 4 | Bus command |
| ad_i | input | 8 | Configuration byte offset; [1:0] must be 00 |
| be_i | input | 4 | Write byte enables, active high |
| wdata_i | input | 32 | Write data |
| vendor_id_i | input | 16 | Vendor identifier |
| device_id_i | input | 16 | Device identifier |
| perr_event_i | input | 1 | Target logic detected a parity error |
| serr_event_i | input | 1 | Target logic signalled a system error |
| mem_addr_i | input | 32 | Memory cycle address to decode |
| cfg_hit_o | output | 1 | Configuration cycle claimed |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data |
| mem_en_o | output | 1 | Memory space enable |
| perr_resp_o | output | 1 | Parity error response enable |
| serr_en_o | output | 1 | System error enable |
| mem_hit_o | output | 1 | Memory address falls in the window |

## Verification
Two things can happen to the status bits in the same cycle: the target logic can raise an error event while software writes 1 to clear that same bit. The bench raises the events at random, and mixes them with writes to offset 0x04 that carry random data and random byte enables. A model that clears first and then sets predicts the result, and a later read of 0x04 checks the bit. A claimed read can also coincide with an event. The read then has to return the status as it stood before that clock edge.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;
  localparam int unsigned CFG_AW = 8;
  localparam int unsigned IDX_W  = CFG_AW - 2;

  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;

  // dword indices that carry content
  localparam logic [IDX_W-1:0] IDX_ID    = 6'h00;
  localparam logic [IDX_W-1:0] IDX_CMDST = 6'h01;
  localparam logic [IDX_W-1:0] IDX_CLASS = 6'h02;
  localparam logic [IDX_W-1:0] IDX_BAR   = 6'h04;
  localparam logic [IDX_W-1:0] IDX_INT   = 6'h0F;

  typedef struct packed {
    logic mem_en;
    logic perr_resp;
    logic serr_en;
  } cmd_t;

  typedef struct packed {
    logic perr_det;
    logic serr_sig;
  } sts_t;
endpackage

// File: rtl/pci_cfg_decode.sv
module pci_cfg_decode
  import pci_cfg_pkg::*;
(
  input  logic              idsel_i,
  input  logic [3:0]        cmd_i,
  input  logic [CFG_AW-1:0] ad_i,
  output logic              hit_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic is_cfg;

  assign is_cfg = (cmd_i == CMD_CFG_RD) || (cmd_i == CMD_CFG_WR);
  assign hit_o  = idsel_i && is_cfg && (ad_i[1:0] == 2'b00);
  assign rd_o   = hit_o && (cmd_i == CMD_CFG_RD);
  assign wr_o   = hit_o && (cmd_i == CMD_CFG_WR);
  assign idx_o  = ad_i[CFG_AW-1:2];
endmodule

// File: rtl/pci_cfg_regs.sv
module pci_cfg_regs
  import pci_cfg_pkg::*;
#(
  parameter int unsigned WIN_BITS = 20,
  localparam int unsigned BASE_W = 32 - WIN_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wdata_i,
  input  logic              perr_event_i,
  input  logic              serr_event_i,
  output cmd_t              cmd_o,
  output sts_t              sts_o,
  output logic [BASE_W-1:0] base_o,
  output logic [7:0]        int_line_o
);
  logic [31:0] lane_mask;
  logic [31:0] wmask;

  // expand byte enables to a bit mask
  for (genvar b = 0; b < 4; b++) begin : g_lane
    assign lane_mask[8*b +: 8] = {8{be_i[b]}};
  end

  assign wmask = wr_i ? lane_mask : 32'h0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o      <= '0;
      sts_o      <= '0;
      base_o     <= '0;
      int_line_o <= '0;
    end else begin
      if (idx_i == IDX_CMDST) begin
        if (wmask[1]) cmd_o.mem_en    <= wdata_i[1];
        if (wmask[6]) cmd_o.perr_resp <= wdata_i[6];
        if (wmask[8]) cmd_o.serr_en   <= wdata_i[8];
      end
      // write-1-to-clear; a same-cycle event wins
      sts_o.perr_det <= perr_event_i |
        (sts_o.perr_det & ~(idx_i == IDX_CMDST && wmask[31] && wdata_i[31]));
      sts_o.serr_sig <= serr_event_i |
        (sts_o.serr_sig & ~(idx_i == IDX_CMDST && wmask[30] && wdata_i[30]));
      if (idx_i == IDX_BAR) begin
        for (int i = 0; i < BASE_W; i++) begin
          if (wmask[WIN_BITS+i]) base_o[i] <= wdata_i[WIN_BITS+i];
        end
      end
      if (idx_i == IDX_INT && wmask[0]) int_line_o <= wdata_i[7:0];
    end
  end
endmodule

// File: rtl/pci_cfg_rdmux.sv
module pci_cfg_rdmux
  import pci_cfg_pkg::*;
#(
  parameter int unsigned WIN_BITS   = 20,
  parameter logic [23:0] CLASS_CODE = 24'h118000,
  localparam int unsigned BASE_W = 32 - WIN_BITS
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [15:0]       vendor_id_i,
  input  logic [15:0]       device_id_i,
  input  cmd_t              cmd_i,
  input  sts_t              sts_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [7:0]        int_line_i,
  output logic [31:0]       data_o
);
  always_comb begin
    data_o = '0;
    unique case (idx_i)
      IDX_ID:    data_o = {device_id_i, vendor_id_i};
      IDX_CMDST: begin
        data_o[31] = sts_i.perr_det;
        data_o[30] = sts_i.serr_sig;
        data_o[8]  = cmd_i.serr_en;
        data_o[6]  = cmd_i.perr_resp;
        data_o[1]  = cmd_i.mem_en;
      end
      IDX_CLASS: data_o = {CLASS_CODE, 8'h00};
      IDX_BAR:   data_o = {base_i, {WIN_BITS{1'b0}}};
      IDX_INT:   data_o = {16'h0000, 8'h01, int_line_i};
      default:   data_o = '0;
    endcase
  end
endmodule

// File: rtl/pci_cfg_space.sv
module pci_cfg_space
  import pci_cfg_pkg::*;
#(
  parameter int unsigned WIN_BITS   = 20,
  parameter logic [23:0] CLASS_CODE = 24'h118000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idsel_i,
  input  logic [3:0]        cmd_i,
  input  logic [CFG_AW-1:0] ad_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wdata_i,
  input  logic [15:0]       vendor_id_i,
  input  logic [15:0]       device_id_i,
  input  logic              perr_event_i,
  input  logic              serr_event_i,
  input  logic [31:0]       mem_addr_i,
  output logic              cfg_hit_o,
  output logic              rvalid_o,
  output logic [31:0]       rdata_o,
  output logic              mem_en_o,
  output logic              perr_resp_o,
  output logic              serr_en_o,
  output logic              mem_hit_o
);
  localparam int unsigned BASE_W = 32 - WIN_BITS;

  logic              rd, wr;
  logic [IDX_W-1:0]  idx;
  cmd_t              cmd_q;
  sts_t              sts_q;
  logic [BASE_W-1:0] base_q;
  logic [7:0]        int_line_q;
  logic [31:0]       rd_mux;

  pci_cfg_decode u_dec (
    .idsel_i (idsel_i),
    .cmd_i   (cmd_i),
    .ad_i    (ad_i),
    .hit_o   (cfg_hit_o),
    .rd_o    (rd),
    .wr_o    (wr),
    .idx_o   (idx)
  );

  pci_cfg_regs #(.WIN_BITS(WIN_BITS)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr),
    .idx_i        (idx),
    .be_i         (be_i),
    .wdata_i      (wdata_i),
    .perr_event_i (perr_event_i),
    .serr_event_i (serr_event_i),
    .cmd_o        (cmd_q),
    .sts_o        (sts_q),
    .base_o       (base_q),
    .int_line_o   (int_line_q)
  );

  pci_cfg_rdmux #(.WIN_BITS(WIN_BITS), .CLASS_CODE(CLASS_CODE)) u_mux (
    .idx_i       (idx),
    .vendor_id_i (vendor_id_i),
    .device_id_i (device_id_i),
    .cmd_i       (cmd_q),
    .sts_i       (sts_q),
    .base_i      (base_q),
    .int_line_i  (int_line_q),
    .data_o      (rd_mux)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd;
      if (rd) rdata_o <= rd_mux;
    end
  end

  assign mem_en_o    = cmd_q.mem_en;
  assign perr_resp_o = cmd_q.perr_resp;
  assign serr_en_o   = cmd_q.serr_en;
  assign mem_hit_o   = cmd_q.mem_en && (mem_addr_i[31:WIN_BITS] == base_q);
endmodule

// File: rtl/pci_cfg_space_chk.sv
module pci_cfg_space_chk #(
  parameter int unsigned WIN_BITS = 20
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        idsel_i,
  input logic [3:0]  cmd_i,
  input logic [7:0]  ad_i,
  input logic        cfg_hit_o,
  input logic        rvalid_o,
  input logic [31:0] rdata_o,
  input logic        mem_en_o,
  input logic        mem_hit_o
);
  a_r1_no_claim_without_idsel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idsel_i |-> !cfg_hit_o);

  a_r2_rvalid_follows_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_hit_o && cmd_i == 4'b1010) |=> rvalid_o);

  a_r3_ext_space_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_hit_o && cmd_i == 4'b1010 && ad_i[7:6] != 2'b00) |=> (rdata_o == 32'h0));

  a_r4_window_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_hit_o && cmd_i == 4'b1010 && ad_i == 8'h10) |=> (rdata_o[WIN_BITS-1:0] == '0));

  a_r6_int_pin_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_hit_o && cmd_i == 4'b1010 && ad_i == 8'h3C) |=> (rdata_o[15:8] == 8'h01));

  a_r7_no_hit_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_en_o |-> !mem_hit_o);
endmodule

bind pci_cfg_space pci_cfg_space_chk #(.WIN_BITS(WIN_BITS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .idsel_i   (idsel_i),
  .cmd_i     (cmd_i),
  .ad_i      (ad_i),
  .cfg_hit_o (cfg_hit_o),
  .rvalid_o  (rvalid_o),
  .rdata_o   (rdata_o),
  .mem_en_o  (mem_en_o),
  .mem_hit_o (mem_hit_o)
);

// File: tb/pci_cfg_space_tb.sv
module pci_cfg_space_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [23:0] CLASS = 24'h118000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        idsel_i = 1'b0;
  logic [3:0]  cmd_i = 4'h0;
  logic [7:0]  ad_i = 8'h0;
  logic [3:0]  be_i = 4'h0;
  logic [31:0] wdata_i = '0;
  logic [15:0] vendor_id_i = 16'h0FFF;
  logic [15:0] device_id_i = 16'h0101;
  logic        perr_event_i = 1'b0;
  logic        serr_event_i = 1'b0;
  logic [31:0] mem_addr_i = '0;
  logic        cfg_hit_o, rvalid_o, mem_en_o, perr_resp_o, serr_en_o, mem_hit_o;
  logic [31:0] rdata_o;

  int n_vec = 0;
  int n_err = 0;

  // model state
  logic m_mem, m_perr_r, m_serr_e, m_pdet, m_ssig;
  logic [11:0] m_base;
  logic [7:0]  m_line;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_cfg_space u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .idsel_i(idsel_i), .cmd_i(cmd_i), .ad_i(ad_i),
    .be_i(be_i), .wdata_i(wdata_i), .vendor_id_i(vendor_id_i), .device_id_i(device_id_i),
    .perr_event_i(perr_event_i), .serr_event_i(serr_event_i), .mem_addr_i(mem_addr_i),
    .cfg_hit_o(cfg_hit_o), .rvalid_o(rvalid_o), .rdata_o(rdata_o), .mem_en_o(mem_en_o),
    .perr_resp_o(perr_resp_o), .serr_en_o(serr_en_o), .mem_hit_o(mem_hit_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic exp_hit(logic sel, logic [3:0] c, logic [7:0] a);
    return sel && (c == 4'b1010 || c == 4'b1011) && a[1:0] == 2'b00;
  endfunction

  function automatic logic [31:0] exp_read(logic [7:0] a);
    case (a)
      8'h00: return {device_id_i, vendor_id_i};
      8'h04: return {m_pdet, m_ssig, 21'h0, m_serr_e, 1'b0, m_perr_r, 4'h0, m_mem, 1'b0};
      8'h08: return {CLASS, 8'h00};
      8'h10: return {m_base, 20'h0};
      8'h3C: return {16'h0, 8'h01, m_line};
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_reset();
    m_mem = 0; m_perr_r = 0; m_serr_e = 0; m_pdet = 0; m_ssig = 0;
    m_base = '0; m_line = '0;
  endtask

  // state update at a clock edge (R5, R6, R8, R9)
  task automatic model_edge(logic wr, logic [7:0] a, logic [3:0] be, logic [31:0] d,
                            logic pe, logic se);
    logic clr_p, clr_s;
    clr_p = wr && a == 8'h04 && be[3] && d[31];
    clr_s = wr && a == 8'h04 && be[3] && d[30];
    m_pdet = pe | (m_pdet & ~clr_p);
    m_ssig = se | (m_ssig & ~clr_s);
    if (wr && a == 8'h04) begin
      if (be[0]) begin m_mem = d[1]; m_perr_r = d[6]; end
      if (be[1]) m_serr_e = d[8];
    end
    if (wr && a == 8'h10) begin
      if (be[2]) m_base[3:0] = d[23:20];
      if (be[3]) m_base[11:4] = d[31:24];
    end
    if (wr && a == 8'h3C && be[0]) m_line = d[7:0];
  endtask

  // one bus cycle: drive at negedge, check claim/mem decode, then read data after edge
  task automatic cycle(string req, logic sel, logic [3:0] c, logic [7:0] a, logic [3:0] be,
                       logic [31:0] d, logic pe, logic se, logic [31:0] maddr);
    logic h, rd, wr;
    logic [31:0] er;
    @(negedge clk);
    idsel_i = sel; cmd_i = c; ad_i = a; be_i = be; wdata_i = d;
    perr_event_i = pe; serr_event_i = se; mem_addr_i = maddr;
    #1;
    h  = exp_hit(sel, c, a);
    rd = h && c == 4'b1010;
    wr = h && c == 4'b1011;
    check("R1 hit", {31'h0, cfg_hit_o}, {31'h0, h});
    check("R7 mem_hit", {31'h0, mem_hit_o}, {31'h0, m_mem && maddr[31:20] == m_base});
    er = exp_read(a);
    @(posedge clk);
    #1;
    model_edge(wr, a, be, d, pe, se);
    check("R2 rvalid", {31'h0, rvalid_o}, {31'h0, rd});
    if (rd) check({req, " rdata"}, rdata_o, er);
    check("R5 enables", {29'h0, mem_en_o, perr_resp_o, serr_en_o},
          {29'h0, m_mem, m_perr_r, m_serr_e});
  endtask

  task automatic cfg_wr(string req, logic [7:0] a, logic [3:0] be, logic [31:0] d);
    cycle(req, 1'b1, 4'b1011, a, be, d, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic cfg_rd(string req, logic [7:0] a);
    cycle(req, 1'b1, 4'b1010, a, 4'h0, 32'h0, 1'b0, 1'b0, 32'h0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_vec++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin : stim
    int unsigned seed;
    seed = 32'd12345;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state visible at the ports
    check("R10 mem_en", {31'h0, mem_en_o}, 32'h0);
    check("R10 rvalid", {31'h0, rvalid_o}, 32'h0);
    @(negedge clk) rst_ni = 1'b1;

    cfg_rd("R10 cmd", 8'h04);
    cfg_rd("R10 bar", 8'h10);
    cfg_rd("R10 line", 8'h3C);
    cfg_rd("R3 id", 8'h00);
    cfg_rd("R3 class", 8'h08);
    cfg_rd("R3 header", 8'h0C);
    cfg_rd("R3 ext", 8'h40);
    cfg_rd("R3 ext", 8'hFC);
    // R4: all-ones write keeps low bits zero
    cfg_wr("R4 bar", 8'h10, 4'hF, 32'hFFFF_FFFF);
    cfg_rd("R4 bar", 8'h10);
    // R9: lane 3 only
    cfg_wr("R9 bar", 8'h10, 4'h8, 32'h0000_0000);
    cfg_rd("R9 bar", 8'h10);
    // R5: only designated bits are writable
    cfg_wr("R5 cmd", 8'h04, 4'h3, 32'h0000_FFFF);
    cfg_rd("R5 cmd", 8'h04);
    // R7: in and out of the window
    cycle("R7 in", 1'b0, 4'h0, 8'h0, 4'h0, 32'h0, 1'b0, 1'b0, 32'h00F1_2345);
    cycle("R7 out", 1'b0, 4'h0, 8'h0, 4'h0, 32'h0, 1'b0, 1'b0, 32'h0101_0000);
    // R6
    cfg_wr("R6 line", 8'h3C, 4'h1, 32'hFFFF_FF5A);
    cfg_rd("R6 line", 8'h3C);
    // R9: read-only / unimplemented targets
    cfg_wr("R9 id", 8'h00, 4'hF, 32'hDEAD_BEEF);
    cfg_wr("R9 ext", 8'h80, 4'hF, 32'hFFFF_FFFF);
    cfg_rd("R9 id", 8'h00);
    cfg_rd("R9 cmd", 8'h04);
    // R1: misaligned and wrong command or no select
    cycle("R1 misalign", 1'b1, 4'b1010, 8'h05, 4'h0, 32'h0, 1'b0, 1'b0, 32'h0);
    cycle("R1 memrd", 1'b1, 4'b0110, 8'h04, 4'h0, 32'h0, 1'b0, 1'b0, 32'h0);
    cycle("R1 nosel", 1'b0, 4'b1011, 8'h04, 4'hF, 32'h0, 1'b0, 1'b0, 32'h0);
    cfg_rd("R1 after", 8'h04);
    // R8: set, clear, set wins over clear
    cycle("R8 set", 1'b0, 4'h0, 8'h0, 4'h0, 32'h0, 1'b1, 1'b1, 32'h0);
    cfg_rd("R8 set", 8'h04);
    cfg_wr("R8 clr", 8'h04, 4'h8, 32'h8000_0000);
    cfg_rd("R8 clr", 8'h04);
    cycle("R8 race", 1'b1, 4'b1011, 8'h04, 4'h8, 32'hC000_0000, 1'b0, 1'b1, 32'h0);
    cfg_rd("R8 race", 8'h04);
    // R3: changed identity
    vendor_id_i = 16'h1234; device_id_i = 16'hABCD;
    cfg_rd("R3 id2", 8'h00);

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] c;
      logic [7:0] a;
      logic [31:0] ma;
      int unsigned pick;
      pick = $urandom_range(0, 9);
      c = (pick < 4) ? 4'b1010 : (pick < 8) ? 4'b1011 : 4'($urandom);
      case ($urandom_range(0, 3))
        0: a = 8'($urandom);
        1: a = 8'h04;
        default: a = {2'b00, 4'($urandom_range(0, 15)), 2'b00};
      endcase
      ma = $urandom_range(0, 1) ? {m_base, 20'($urandom)} : $urandom;
      cycle("R8 rand", $urandom_range(0, 7) != 0, c, a, 4'($urandom), $urandom,
            $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0, ma);
    end

    // R10: reset mid-run clears state again
    @(negedge clk) rst_ni = 1'b0;
    model_reset();
    @(negedge clk) rst_ni = 1'b1;
    cfg_rd("R10 cmd2", 8'h04);
    cfg_rd("R10 bar2", 8'h10);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule